// File: doc/BRIEF.md
# ADC Sequencer Wait/Freeze Controller

This block is the digital control shell around a successive-approximation conversion sequencer. It takes a write start from a small register bus and runs a fixed-length sequence of conversions. A behavioural timer stands in for the analog conversion time: each conversion opens with a sample window and ends with a done strobe. The controller also decides how the sequencer reacts to four outside events: a low-power wait request, a debug freeze request, a system reset and a soft reset issued through a test register.

Wait handling is optional. When it is enabled, the module powers down, gates its timing clock and closes the register file to the bus. Debug freeze has three behaviours, chosen by a two-bit field. While frozen, the timing position is held and the registers stay open. The soft reset returns the module to idle but keeps the power-up setting. System reset leaves the module powered down.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control bit 1 enables the wait response. With it set, a high `wait_req` moves `state` to 4 (wait) at the next edge from any state. With it clear, `wait_req` has no effect.
- R2: In the wait state the following hold:
  - `reg_access_ok`, `clk_en` and `sample_en` are low.
  - `reg_rdata` reads 0.
  - Writes to either register are dropped.
- R3: Control bits 3:2 hold the freeze mode: 00 and 01 ignore `dbg_freeze`, 10 is finish-then-freeze, 11 is immediate freeze. In immediate mode, a high `dbg_freeze` during a conversion moves `state` to 3 (frozen) at the next edge, unless that edge completes the last conversion.
- R4: In finish-then-freeze mode, freezing happens only on the edge that completes a conversion when another conversion is still due. The module then sits at position 0 with `sample_en` low, before the next sample window.
- R5: While frozen, `clk_en` is low and `conv_pos` is held. Freezing never adds or drops timing cycles: a sequence always spends exactly SEQ_LEN*CONV_CYCLES cycles in the converting state.
- R6: While frozen, the control register can be written and read back.
- R7: After `dbg_freeze` falls, the frozen state returns to converting (2) at the next edge and resumes from the held position.
- R8: System reset (`rst_n` low) gives the following:
  - `state` 0 (powered down).
  - All control fields are cleared, including power-up.
  - The module stays powered down after release.
- R9: Writing 1 to test-register bit 0 (`reg_sel`=1) is a soft reset. One edge later it clears the wait-enable and freeze fields, keeps power-up, aborts any conversion and moves to idle (1). If power-up is 0, it moves to powered down (0) instead.
- R10: The soft-reset bit reads back 1 in the cycle after it is written and clears itself at the following edge.
- R11: Wait outranks freeze and every state other than soft reset. When `wait_req` falls, the module goes to idle (or powered down if power-up is 0) with no conversion pending.
- R12: A write with control bit 4 set, made in idle, starts SEQ_LEN conversions of CONV_CYCLES cycles each:
  - `sample_en` is high for the first SAMPLE_CYCLES cycles of each conversion.
  - `conv_done` pulses once per conversion.
  - After the last conversion, `state` returns to 1.
  - A start bit written in any other state is ignored.
- R13: `state` encoding: 0 powered down, 1 idle, 2 converting, 3 frozen, 4 wait. Control bit 0 is power-up. Setting it moves state 0 to 1. Clearing it moves idle, converting or frozen to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| wait_req | input | 1 | Low-power wait request |
| dbg_freeze | input | 1 | Debug freeze request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 the test register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (0 when access is blocked) |
| sample_en | output | 1 | Sample window enable |
| clk_en | output | 1 | Clock-gate enable for the conversion timing logic |
| reg_access_ok | output | 1 | Register file reachable from the bus |
| conv_done | output | 1 | One-cycle strobe at the end of each conversion |
| conv_pos | output | clog2(CONV_CYCLES) | Cycle position within the current conversion |
| state | output | 3 | Controller state, encoded as in R13 |

## Verification
The bench sweeps all four freeze codes against every point in the sequence at which the freeze request can rise, and computes the frozen duration arithmetically for each case. A design that froze mid-conversion in finish mode, or lost or repeated a timing cycle across a freeze, would show a wrong frozen count, a wrong converting count or a moving held position. It drives wait during a freeze and writes during wait, so a controller that let freeze win or let writes through would hold the wrong state or read back altered fields. It also places the soft reset both mid-conversion and while powered down, which exposes a soft reset that clears power-up or a reset bit that never clears itself.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_PDOWN  = 3'd0,
      ST_IDLE   = 3'd1,
      ST_CONV   = 3'd2,
      ST_FROZEN = 3'd3,
      ST_WAIT   = 3'd4
   } seq_state_e;

   typedef enum logic [1:0] {
      FRZ_OFF    = 2'b00,
      FRZ_RSVD   = 2'b01,
      FRZ_FINISH = 2'b10,
      FRZ_NOW    = 2'b11
   } frz_mode_e;

   typedef struct packed {
      logic [1:0] frz_sel;
      logic       wait_en;
      logic       pwr_up;
   } ctrl_fields_t;

   localparam int CTRL_PWR_BIT   = 0;
   localparam int CTRL_WAIT_BIT  = 1;
   localparam int CTRL_FRZ_LSB   = 2;
   localparam int CTRL_START_BIT = 4;
   localparam int TEST_RST_BIT   = 0;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              access_ok,
   output logic [DATA_W-1:0] rdata,
   output ctrl_fields_t      ctrl,
   output logic              start_req,
   output logic              soft_rst
);

   if (DATA_W < CTRL_START_BIT + 1) begin : g_bad_width
      $error("adc_seq_regs: DATA_W cannot hold the control fields");
   end

   logic wr_ok;
   logic unused_wdata;

   assign unused_wdata = ^wdata;
   assign wr_ok        = wr && access_ok && !soft_rst;
   assign start_req    = wr_ok && !sel && wdata[CTRL_START_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         soft_rst <= 1'b0;
      end else if (soft_rst) begin
         ctrl     <= {2'b00, 1'b0, ctrl.pwr_up};
         soft_rst <= 1'b0;
      end else if (wr_ok) begin
         if (sel) begin
            soft_rst <= wdata[TEST_RST_BIT];
         end else begin
            ctrl.pwr_up  <= wdata[CTRL_PWR_BIT];
            ctrl.wait_en <= wdata[CTRL_WAIT_BIT];
            ctrl.frz_sel <= wdata[CTRL_FRZ_LSB +: 2];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (access_ok) begin
         if (sel) begin
            rdata[TEST_RST_BIT] = soft_rst;
         end else begin
            rdata[CTRL_PWR_BIT]       = ctrl.pwr_up;
            rdata[CTRL_WAIT_BIT]      = ctrl.wait_en;
            rdata[CTRL_FRZ_LSB +: 2]  = ctrl.frz_sel;
         end
      end
   end

   // R2: a write attempted while access is closed changes nothing
   p_blocked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !access_ok && !soft_rst) |=> ($stable(ctrl) && !soft_rst));

   // R10: the soft-reset bit lives for one cycle only
   p_self_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst);

   // R9: soft reset keeps power-up and clears the other fields
   p_keep_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl.pwr_up == $past(ctrl.pwr_up)) && !ctrl.wait_en && (ctrl.frz_sel == 2'b00));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
   parameter int CONV_CYCLES   = 10,
   parameter int SAMPLE_CYCLES = 4,
   localparam int POS_W = $clog2(CONV_CYCLES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [POS_W-1:0] pos,
   output logic             done,
   output logic             in_sample
);

   if (CONV_CYCLES < 2) begin : g_bad_conv
      $error("adc_conv_timer: CONV_CYCLES must be at least 2");
   end
   if (SAMPLE_CYCLES < 1 || SAMPLE_CYCLES >= CONV_CYCLES) begin : g_bad_sample
      $error("adc_conv_timer: SAMPLE_CYCLES must lie in 1..CONV_CYCLES-1");
   end

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(CONV_CYCLES - 1);
   localparam logic [POS_W-1:0] SAMP_END = POS_W'(SAMPLE_CYCLES);

   assign done      = adv && (pos == LAST_POS);
   assign in_sample = (pos < SAMP_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pos <= '0;
      else if (clr)    pos <= '0;
      else if (done)   pos <= '0;
      else if (adv)    pos <= pos + 1'b1;
   end

   // R5: with the timing clock gated the position cannot move
   p_hold_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(pos));

   // R12: a completed conversion restarts at position zero
   p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (pos == '0));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int SEQ_LEN = 4
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wait_req,
   input  logic         dbg_freeze,
   input  ctrl_fields_t ctrl,
   input  logic         start_req,
   input  logic         soft_rst,
   input  logic         done,
   output seq_state_e   state_q,
   output logic         tmr_clr
);

   if (SEQ_LEN < 1) begin : g_bad_seq
      $error("adc_seq_fsm: SEQ_LEN must be at least 1");
   end

   localparam int LEFT_W = $clog2(SEQ_LEN + 1);

   seq_state_e nxt;
   logic       wait_hit;
   logic       frz_now;
   logic       frz_fin;
   logic       launch;
   logic       last_conv;

   assign wait_hit = wait_req && ctrl.wait_en;
   assign frz_now  = dbg_freeze && (ctrl.frz_sel == FRZ_NOW);
   assign frz_fin  = dbg_freeze && (ctrl.frz_sel == FRZ_FINISH);
   assign launch   = (state_q == ST_IDLE) && (nxt == ST_CONV);
   assign tmr_clr  = (nxt != ST_CONV) && (nxt != ST_FROZEN);

   if (SEQ_LEN == 1) begin : g_single
      assign last_conv = 1'b1;
   end else begin : g_multi
      logic [LEFT_W-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            left_q <= '0;
         else if (launch)
            left_q <= LEFT_W'(SEQ_LEN);
         else if (done && (state_q == ST_CONV) && (left_q != '0))
            left_q <= left_q - 1'b1;
      end
      assign last_conv = (left_q == LEFT_W'(1));

      // R12: the remaining-conversion count never exceeds the sequence length
      p_left_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
         left_q <= LEFT_W'(SEQ_LEN));
   end

   always_comb begin
      nxt = state_q;
      if (soft_rst) begin
         nxt = ctrl.pwr_up ? ST_IDLE : ST_PDOWN;
      end else if (wait_hit) begin
         nxt = ST_WAIT;
      end else begin
         case (state_q)
            ST_WAIT:   nxt = ctrl.pwr_up ? ST_IDLE : ST_PDOWN;
            ST_PDOWN:  if (ctrl.pwr_up) nxt = ST_IDLE;
            ST_IDLE: begin
               if (!ctrl.pwr_up)   nxt = ST_PDOWN;
               else if (start_req) nxt = ST_CONV;
            end
            ST_CONV: begin
               if (!ctrl.pwr_up)                 nxt = ST_PDOWN;
               else if (done && last_conv)       nxt = ST_IDLE;
               else if (frz_now || (frz_fin && done)) nxt = ST_FROZEN;
            end
            ST_FROZEN: begin
               if (!ctrl.pwr_up)               nxt = ST_PDOWN;
               else if (!(frz_now || frz_fin)) nxt = ST_CONV;
            end
            default:   nxt = ST_PDOWN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_PDOWN;
      else        state_q <= nxt;
   end

   // R1: without the enable bit the wait state is unreachable
   p_wait_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.wait_en |=> (state_q != ST_WAIT));

   // R11: an enabled wait request wins over everything except soft reset
   p_wait_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_hit && !soft_rst) |=> (state_q == ST_WAIT));

   // R11: leaving wait lands in idle or powered down, never converting
   p_wait_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !wait_req && !soft_rst) |=>
         (state_q == ST_IDLE || state_q == ST_PDOWN));

   // R3: immediate mode freezes on the next edge
   p_imm_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV && frz_now && !(done && last_conv) && !wait_hit && !soft_rst && ctrl.pwr_up)
         |=> (state_q == ST_FROZEN));

   // R4: outside immediate mode a freeze only starts at a conversion boundary
   p_fin_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV && !done && ctrl.frz_sel != FRZ_NOW) |=> (state_q != ST_FROZEN));

   // R7: a released freeze resumes converting on the next edge
   p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FROZEN && !dbg_freeze && !wait_hit && !soft_rst && ctrl.pwr_up)
         |=> (state_q == ST_CONV));

   // R9: soft reset lands in idle or powered down
   p_soft_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (state_q == ST_IDLE || state_q == ST_PDOWN));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int CONV_CYCLES   = 10,
   parameter int SAMPLE_CYCLES = 4,
   parameter int SEQ_LEN       = 4,
   localparam int POS_W = $clog2(CONV_CYCLES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wait_req,
   input  logic              dbg_freeze,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sample_en,
   output logic              clk_en,
   output logic              reg_access_ok,
   output logic              conv_done,
   output logic [POS_W-1:0]  conv_pos,
   output logic [2:0]        state
);

   if (CONV_CYCLES < 2 || SEQ_LEN < 1) begin : g_bad_top
      $error("adc_seq_ctrl: CONV_CYCLES >= 2 and SEQ_LEN >= 1 required");
   end

   ctrl_fields_t ctrl;
   seq_state_e   st;
   logic         start_req;
   logic         soft_rst;
   logic         tmr_clr;
   logic         in_sample;

   assign reg_access_ok = (st != ST_WAIT);
   assign clk_en        = (st == ST_CONV);
   assign sample_en     = clk_en && in_sample;
   assign state         = st;

   adc_seq_regs #(
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .sel       (reg_sel),
      .wdata     (reg_wdata),
      .access_ok (reg_access_ok),
      .rdata     (reg_rdata),
      .ctrl      (ctrl),
      .start_req (start_req),
      .soft_rst  (soft_rst)
   );

   adc_conv_timer #(
      .CONV_CYCLES   (CONV_CYCLES),
      .SAMPLE_CYCLES (SAMPLE_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tmr_clr),
      .adv       (clk_en),
      .pos       (conv_pos),
      .done      (conv_done),
      .in_sample (in_sample)
   );

   adc_seq_fsm #(
      .SEQ_LEN (SEQ_LEN)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wait_req   (wait_req),
      .dbg_freeze (dbg_freeze),
      .ctrl       (ctrl),
      .start_req  (start_req),
      .soft_rst   (soft_rst),
      .done       (conv_done),
      .state_q    (st),
      .tmr_clr    (tmr_clr)
   );

   // R2: in wait the block is dark and the bus sees nothing
   p_wait_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'd4) |-> (!sample_en && reg_rdata == '0));

   // R5: a held freeze request keeps the frozen position still
   p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'd3 && dbg_freeze && !wait_req) |=> $stable(conv_pos));

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

   localparam int DW    = 8;
   localparam int CONV  = 4;
   localparam int SAMP  = 2;
   localparam int SEQ   = 3;
   localparam int HOLD  = 4;
   localparam int TOTAL = CONV * SEQ;
   localparam int S_PD = 0, S_ID = 1, S_CV = 2, S_FZ = 3, S_WT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wait_req = 1'b0;
   logic          dbg_freeze = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_sel = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          sample_en;
   logic          clk_en;
   logic          reg_access_ok;
   logic          conv_done;
   logic [1:0]    conv_pos;
   logic [2:0]    st;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   adc_seq_ctrl #(
      .DATA_W        (DW),
      .CONV_CYCLES   (CONV),
      .SAMPLE_CYCLES (SAMP),
      .SEQ_LEN       (SEQ)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .wait_req      (wait_req),
      .dbg_freeze    (dbg_freeze),
      .reg_wr        (reg_wr),
      .reg_sel       (reg_sel),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .sample_en     (sample_en),
      .clk_en        (clk_en),
      .reg_access_ok (reg_access_ok),
      .conv_done     (conv_done),
      .conv_pos      (conv_pos),
      .state         (st)
   );

   task automatic check(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic s, logic [DW-1:0] d);
      @(negedge clk);
      reg_sel   = s;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_reg(logic s, output int v);
      reg_sel = s;
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic run_seq(int mode, int d);
      int  cnv = 0, frz = 0, smp = 0, dn = 0, bad = 0, hc = 0, pos0 = -1, guard = 0;
      int  exp_frz, m;
      bit  armed = 0, fired = 0;
      wr_reg(1'b0, DW'(1 | (mode << 2)));
      wr_reg(1'b0, DW'(1 | (mode << 2) | 16));
      while (int'(st) != S_ID && guard < 200) begin
         if (int'(st) == S_CV) cnv++;
         if (int'(st) == S_FZ) begin
            frz++;
            if (pos0 < 0) pos0 = int'(conv_pos);
            else if (int'(conv_pos) != pos0) bad++;
            if (mode == 2 && (conv_pos != 2'd0 || sample_en)) bad++;
            if (clk_en) bad++;
         end
         smp += int'(sample_en);
         dn  += int'(conv_done);
         if (armed) begin
            hc++;
            if (hc == HOLD) begin
               dbg_freeze = 1'b0;
               armed = 0;
            end
         end else if (!fired && cnv == d) begin
            dbg_freeze = 1'b1;
            armed = 1;
            fired = 1;
            hc = 0;
         end
         guard++;
         @(negedge clk);
      end
      dbg_freeze = 1'b0;
      if (mode == 3) begin
         exp_frz = HOLD;
      end else if (mode == 2) begin
         m = ((d + CONV - 1) / CONV) * CONV;
         exp_frz = (m - d < HOLD && m < TOTAL) ? HOLD - (m - d) : 0;
      end else begin
         exp_frz = 0;
      end
      check("R12 sequence ends in idle", int'(guard < 200), 1);
      check("R5 converting cycles unchanged by freeze", cnv, TOTAL);
      if (mode == 3)      check("R3 immediate freeze length (R7 resume)", frz, exp_frz);
      else if (mode == 2) check("R4 finish-then-freeze length (R7 resume)", frz, exp_frz);
      else                check("R3 freeze ignored for codes 00/01", frz, exp_frz);
      check("R5 position held while frozen (R4 boundary)", bad, 0);
      check("R12 sample window cycles", smp, SEQ * SAMP);
      check("R12 done strobes", dn, SEQ);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int v;
      int p;
      // R8 reset state
      repeat (3) @(negedge clk);
      check("R8 reset state", int'(st), S_PD);
      check("R8 clk_en in reset", int'(clk_en), 0);
      check("R8 access open in reset", int'(reg_access_ok), 1);
      rd_reg(1'b0, v);
      check("R8 control fields cleared", v, 0);
      rst_n = 1'b1;

      // R12 start ignored while powered down
      wr_reg(1'b0, 8'h10);
      @(negedge clk);
      check("R12 start ignored in powered down", int'(st), S_PD);

      // R13 power-up moves to idle
      wr_reg(1'b0, 8'h01);
      @(negedge clk);
      check("R13 power-up reaches idle", int'(st), S_ID);

      // Sweep: every freeze code against every freeze point
      for (int mode = 0; mode < 4; mode++) begin
         for (int d = 1; d < TOTAL; d++) begin
            run_seq(mode, d);
         end
      end

      // R6 register access while frozen
      wr_reg(1'b0, 8'h0D);
      wr_reg(1'b0, 8'h1D);
      @(negedge clk);
      dbg_freeze = 1'b1;
      @(negedge clk);
      check("R3 frozen after immediate request", int'(st), S_FZ);
      p = int'(conv_pos);
      wr_reg(1'b0, 8'h0F);
      rd_reg(1'b0, v);
      check("R6 control write while frozen", v, 8'h0F);
      check("R6 still frozen after write", int'(st), S_FZ);
      check("R5 position held across write", int'(conv_pos), p);

      // R11 wait outranks freeze, R2 blocked access
      wait_req = 1'b1;
      @(negedge clk);
      check("R11 wait over freeze", int'(st), S_WT);
      check("R2 access flag low in wait", int'(reg_access_ok), 0);
      check("R2 clk_en low in wait", int'(clk_en), 0);
      rd_reg(1'b0, v);
      check("R2 read returns zero in wait", v, 0);
      wr_reg(1'b0, 8'h00);
      wr_reg(1'b1, 8'h01);
      check("R2 still in wait after writes", int'(st), S_WT);
      wait_req   = 1'b0;
      dbg_freeze = 1'b0;
      @(negedge clk);
      check("R11 wait exit to idle", int'(st), S_ID);
      repeat (3) @(negedge clk);
      check("R11 no conversion pending after wait", int'(st), S_ID);
      check("R11 timing clock off after wait", int'(clk_en), 0);
      rd_reg(1'b0, v);
      check("R2 control write during wait dropped", v, 8'h0F);
      rd_reg(1'b1, v);
      check("R2 test write during wait dropped", v, 0);

      // R1 wait ignored when disabled
      wr_reg(1'b0, 8'h01);
      wr_reg(1'b0, 8'h11);
      wait_req = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 wait ignored when disabled", int'(st), S_CV);
      check("R1 access kept when disabled", int'(reg_access_ok), 1);
      wait_req = 1'b0;
      repeat (TOTAL) @(negedge clk);
      check("R12 sequence finished", int'(st), S_ID);

      // R1 wait honoured when enabled
      wr_reg(1'b0, 8'h03);
      wr_reg(1'b0, 8'h13);
      wait_req = 1'b1;
      @(negedge clk);
      check("R1 wait honoured when enabled", int'(st), S_WT);
      wait_req = 1'b0;
      @(negedge clk);
      check("R11 wait exit to idle mid-sequence", int'(st), S_ID);

      // R9 / R10 soft reset mid-conversion
      wr_reg(1'b0, 8'h0F);
      wr_reg(1'b0, 8'h1F);
      @(negedge clk);
      wr_reg(1'b1, 8'h01);
      rd_reg(1'b1, v);
      check("R10 reset bit reads one", v, 1);
      check("R9 reset takes effect one edge later", int'(st), S_CV);
      @(negedge clk);
      rd_reg(1'b1, v);
      check("R10 reset bit self-clears", v, 0);
      check("R9 soft reset to idle", int'(st), S_ID);
      rd_reg(1'b0, v);
      check("R9 power-up kept, fields cleared", v, 8'h01);
      check("R9 position cleared", int'(conv_pos), 0);

      // R13 / R9 soft reset while powered down
      wr_reg(1'b0, 8'h00);
      wr_reg(1'b1, 8'h01);
      @(negedge clk);
      check("R13 power-up cleared gives powered down", int'(st), S_PD);
      @(negedge clk);
      check("R9 soft reset keeps powered down", int'(st), S_PD);

      // R8 system reset mid-conversion
      wr_reg(1'b0, 8'h01);
      @(negedge clk);
      wr_reg(1'b0, 8'h11);
      @(negedge clk);
      check("R12 converting before system reset", int'(st), S_CV);
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 system reset to powered down", int'(st), S_PD);
      rd_reg(1'b0, v);
      check("R8 power-up cleared", v, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 stays powered down after release", int'(st), S_PD);

      summary();
      $finish;
   end

endmodule